// File: doc/BRIEF.md
# Multi-Shot Down-Counting Timer with Capture and Kill

This block is a byte-wide down-counter that reloads from a period register each time it passes zero. It produces a terminal-count pulse, a compare output and an interrupt. A shot limit can stop the timer automatically after a chosen number of terminal counts; a limit of zero lets it run without end. The count can be copied into a shared capture/compare register in two ways: by a rising edge on a hardware capture pin, or by a CPU read of the count while the timer runs. The same register then serves as the compare threshold. A kill input either stops the timer until firmware starts it again, or holds it at the reload point until kill is released.

Software uses a small register port, with reads returned combinationally. Address 0 is the count: it is read-only, and reading it while running captures it. Address 1 is the period. Address 2 is capture/compare. Address 3 is the control byte: bit 0 is enable and bits 7:4 are the shot limit. Address 4 is the mode byte: bit 0 selects kill-reload (1) or kill-disable (0), bit 1 selects less-or-equal (1) or strictly-less (0) compare, bit 2 selects compare (1) or terminal count (0) as the interrupt source, bit 3 delays the compare output by half a clock, and bit 4 makes the terminal-count pulse half a clock wide.

The sequencer has three states: Idle, Run and Hold.
- Idle→Run: enable is written as 1 and kill is low.
- Idle→Hold: enable is written as 1 while kill is high in kill-reload mode.
- Run→Idle: enable is written as 0, kill is raised in kill-disable mode, or the last shot completes.
- Run→Hold: kill is raised in kill-reload mode.
- Hold→Run: kill falls.
- Hold→Idle: enable is written as 0, or the mode is switched to kill-disable while kill is high.

Top module: `tmr_multishot`

## Requirements
- R1: After reset, every readable register reads 0, the timer is disabled, and tc_out, cmp_out and irq are low.
- R2: Writing address 1 in Idle loads the value into both the period and the count. Writing it in Run changes only the period.
- R3: In Run the count falls by one each clock. On the clock after the cycle in which it reads 0, it reloads the period, so a period P repeats every P+1 cycles.
- R4: tc_out is high in exactly the Run cycles whose count is 0. With mode bit 4 set it is high only in the clock-high half of that cycle.
- R5: With a non-zero shot limit N (control bits 7:4), the timer returns to Idle at the Nth terminal count, reloading the period, and enable then reads 0. A limit of 0 never stops the timer.
- R6: A rising edge on cap_in copies the current count into address 2. If a capture and a write to address 2 fall in the same cycle, the capture wins.
- R7: A read of address 0 (rd_en high) in Run or Hold captures like a hardware edge. It has no effect while cap_in is high, and no effect while the timer is in Idle.
- R8: Outside Idle, cmp_out is high when count <= capture/compare (mode bit 1 set) or count < capture/compare (mode bit 1 clear). It is 0 in Idle.
- R9: With mode bit 3 set, cmp_out shows the compare result as it was at the previous falling clock edge.
- R10: While kill_in is high, tc_out, cmp_out and irq are 0. In kill-disable mode, kill moves the timer to Idle on the next edge, and a write of enable as 1 is refused.
- R11: In kill-reload mode with kill high, the timer sits in Hold with the count equal to the period and the shot tally cleared. After kill falls it restarts counting down from the period.
- R12: irq follows the terminal-count condition (mode bit 2 clear) or the undelayed compare condition (mode bit 2 set), forced to 0 by kill.
- R13: Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used only to trigger capture) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| cap_in | input | 1 | Hardware capture, rising-edge active |
| kill_in | input | 1 | Kill request |
| tc_out | output | 1 | Terminal-count output |
| cmp_out | output | 1 | Compare output |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same clock. A capture edge can land in the same cycle as a CPU write to the capture/compare register. A kill can arrive in the very cycle the count sits at zero, where it competes with the reload and the shot tally. The bench's random phase toggles cap_in and kill_in independently of random register writes, so both collisions happen many times. A bench reference model, built from the requirements, gives the capture priority over the write and lets kill win over the terminal count. Every cycle's outputs and read data are compared with that model in both clock phases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tmr_state_e;

    // Mode byte, bit 0 = kill_reload ... bit 4 = tc_half
    typedef struct packed {
        logic tc_half;
        logic cmp_delay;
        logic irq_cmp;
        logic cmp_le;
        logic kill_reload;
    } tmr_mode_t;

endpackage

// File: rtl/tmr_seq.sv
module tmr_seq
    import tmr_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic          load_wr,
    input  logic [W-1:0]  load_val,
    input  logic [W-1:0]  period,
    input  logic [SW-1:0] shot_limit,
    input  logic          kill_reload,
    output tmr_state_e    state,
    output logic [W-1:0]  count,
    output logic [SW-1:0] shots
);

    tmr_state_e    st_n;
    logic [W-1:0]  cnt_n;
    logic [SW-1:0] sh_n;
    logic          at_zero;
    logic          last_shot;

    assign at_zero   = (count == '0);
    assign last_shot = (shot_limit != '0) && ((shots + SW'(1)) == shot_limit);

    // Next-state and datapath decision
    always_comb begin
        st_n  = state;
        cnt_n = count;
        sh_n  = shots;
        unique case (state)
            ST_IDLE: begin
                if (load_wr) begin
                    cnt_n = load_val;
                end
                if (en_set && !(kill && !kill_reload)) begin
                    sh_n = '0;
                    if (kill) begin
                        st_n  = ST_HOLD;
                        cnt_n = period;
                    end else begin
                        st_n = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (en_clr) begin
                    st_n = ST_IDLE;
                end else if (kill) begin
                    if (kill_reload) begin
                        st_n  = ST_HOLD;
                        cnt_n = period;
                        sh_n  = '0;
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else if (at_zero) begin
                    cnt_n = period;
                    sh_n  = shots + SW'(1);
                    if (last_shot) begin
                        st_n = ST_IDLE;
                    end
                end else begin
                    cnt_n = count - W'(1);
                end
            end
            ST_HOLD: begin
                cnt_n = period;
                sh_n  = '0;
                if (en_clr) begin
                    st_n = ST_IDLE;
                end else if (kill && !kill_reload) begin
                    st_n = ST_IDLE;
                end else if (!kill) begin
                    st_n = ST_RUN;
                end
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
            shots <= '0;
        end else begin
            state <= st_n;
            count <= cnt_n;
            shots <= sh_n;
        end
    end

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_in,
    input  logic         sw_rd,
    input  logic [W-1:0] count,
    input  logic         cc_wr,
    input  logic [W-1:0] cc_wdata,
    output logic [W-1:0] cc,
    output logic         cap_edge
);

    logic src;
    logic src_prev;

    // Hardware and software requests merge before the edge detector
    assign src      = cap_in | sw_rd;
    assign cap_edge = src & ~src_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= 1'b0;
            cc       <= '0;
        end else begin
            src_prev <= src;
            if (cap_edge) begin
                cc <= count;
            end else if (cc_wr) begin
                cc <= cc_wdata;
            end
        end
    end

endmodule

// File: rtl/tmr_outs.sv
module tmr_outs
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tmr_state_e   state,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cc,
    input  tmr_mode_t    mode,
    input  logic         kill,
    output logic         tc_out,
    output logic         cmp_out,
    output logic         irq
);

    logic tc_raw;
    logic cmp_raw;
    logic cmp_late;

    assign tc_raw  = (state == ST_RUN) && (count == '0);
    assign cmp_raw = (state != ST_IDLE) &&
                     (mode.cmp_le ? (count <= cc) : (count < cc));

    // Half-cycle retimed copy of the compare result
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_late <= 1'b0;
        end else begin
            cmp_late <= cmp_raw;
        end
    end

    always_comb begin
        tc_out  = tc_raw & ~kill & (mode.tc_half ? clk : 1'b1);
        cmp_out = ~kill & (mode.cmp_delay ? cmp_late : cmp_raw);
        irq     = ~kill & (mode.irq_cmp ? cmp_raw : tc_raw);
    end

endmodule

// File: rtl/tmr_multishot.sv
module tmr_multishot
    import tmr_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              cap_in,
    input  logic              kill_in,
    output logic              tc_out,
    output logic              cmp_out,
    output logic              irq
);

    localparam int MODE_W = $bits(tmr_mode_t);

    logic [W-1:0]  period_q;
    logic [SW-1:0] shot_lim_q;
    tmr_mode_t     mode_q;
    tmr_state_e    state;
    logic [W-1:0]  count;
    logic [SW-1:0] shots;
    logic [W-1:0]  cc;
    logic          cap_edge;
    logic          wr_period;
    logic          wr_cmp;
    logic          wr_ctrl;
    logic          wr_mode;
    logic          sw_rd;
    logic [W-1:0]  ctrl_rd;

    assign wr_period = wr_en && (addr == A_PERIOD);
    assign wr_cmp    = wr_en && (addr == A_CMP);
    assign wr_ctrl   = wr_en && (addr == A_CTRL);
    assign wr_mode   = wr_en && (addr == A_MODE);
    assign sw_rd     = rd_en && (addr == A_COUNT) && (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q   <= '0;
            shot_lim_q <= '0;
            mode_q     <= '0;
        end else begin
            if (wr_period) period_q   <= wdata;
            if (wr_ctrl)   shot_lim_q <= wdata[W-1 -: SW];
            if (wr_mode)   mode_q     <= tmr_mode_t'(wdata[MODE_W-1:0]);
        end
    end

    tmr_seq #(.W(W), .SW(SW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill        (kill_in),
        .en_set      (wr_ctrl && wdata[0]),
        .en_clr      (wr_ctrl && !wdata[0]),
        .load_wr     (wr_period),
        .load_val    (wdata),
        .period      (period_q),
        .shot_limit  (shot_lim_q),
        .kill_reload (mode_q.kill_reload),
        .state       (state),
        .count       (count),
        .shots       (shots)
    );

    tmr_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .sw_rd    (sw_rd),
        .count    (count),
        .cc_wr    (wr_cmp),
        .cc_wdata (wdata),
        .cc       (cc),
        .cap_edge (cap_edge)
    );

    tmr_outs #(.W(W)) u_outs (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .count   (count),
        .cc      (cc),
        .mode    (mode_q),
        .kill    (kill_in),
        .tc_out  (tc_out),
        .cmp_out (cmp_out),
        .irq     (irq)
    );

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[0]         = (state != ST_IDLE);
        ctrl_rd[W-1 -: SW] = shot_lim_q;
    end

    always_comb begin
        case (addr)
            A_COUNT:  rdata = count;
            A_PERIOD: rdata = period_q;
            A_CMP:    rdata = cc;
            A_CTRL:   rdata = ctrl_rd;
            A_MODE:   rdata = W'(mode_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_multishot_chk.sv
module tmr_multishot_chk
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kill,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input tmr_state_e        state,
    input logic [W-1:0]      count,
    input logic [W-1:0]      period,
    input logic [W-1:0]      cc,
    input logic              cap_edge,
    input logic              kill_reload,
    input logic              tc_out,
    input logic              cmp_out,
    input logic              irq
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == A_CTRL);

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && count != '0 && !kill && !ctrl_wr)
        |=> count == $past(count) - W'(1));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && count == '0 && !kill && !ctrl_wr)
        |=> count == $past(period));

    a_r10_kill_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && kill && !kill_reload)
        |=> state == ST_IDLE);

    a_r10_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> (!tc_out && !cmp_out && !irq));

    a_r11_hold_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && kill && kill_reload && !ctrl_wr)
        |=> (state == ST_HOLD && count == $past(period)));

    a_r6_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
        cap_edge |=> cc == $past(count));

endmodule

bind tmr_multishot tmr_multishot_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .kill        (kill_in),
    .wr_en       (wr_en),
    .addr        (addr),
    .state       (state),
    .count       (count),
    .period      (period_q),
    .cc          (cc),
    .cap_edge    (cap_edge),
    .kill_reload (mode_q.kill_reload),
    .tc_out      (tc_out),
    .cmp_out     (cmp_out),
    .irq         (irq)
);

// File: tb/tmr_multishot_tb_top.sv
module tmr_multishot_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, cap = 1'b0, kill = 1'b0;
    logic [2:0] ad = 3'd0;
    logic [7:0] wd = 8'd0;
    logic [7:0] rdata;
    logic       tc_o, cmp_o, irq_o;

    always #5 clk = ~clk;

    tmr_multishot dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr), .rd_en(rd), .addr(ad),
        .wdata(wd), .rdata(rdata), .cap_in(cap), .kill_in(kill),
        .tc_out(tc_o), .cmp_out(cmp_o), .irq(irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model (0 idle, 1 run, 2 hold)
    int         m_st = 0;
    logic [7:0] m_cnt = 0, m_per = 0, m_cc = 0;
    logic [3:0] m_lim = 0, m_sh = 0;
    logic [4:0] m_mode = 0;
    logic       m_capprev = 0, m_cmpprev = 0;
    logic [7:0] last_rd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_tc();
        return (m_st == 1) && (m_cnt == 8'd0);
    endfunction

    function automatic logic m_cmp();
        return (m_st != 0) && (m_mode[1] ? (m_cnt <= m_cc) : (m_cnt < m_cc));
    endfunction

    function automatic logic [7:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0:    return m_cnt;
            3'd1:    return m_per;
            3'd2:    return m_cc;
            3'd3:    return {m_lim, 3'b000, (m_st != 0)};
            3'd4:    return {3'b000, m_mode};
            default: return 8'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0:    return "R3";
            3'd1:    return "R2";
            3'd2:    return "R6";
            3'd3:    return "R5";
            default: return "R1";
        endcase
    endfunction

    // Entered at posedge+1; checks both phases, then advances the model
    task automatic step();
        logic [7:0] n_cnt, n_cc, n_per;
        logic [3:0] n_lim, n_sh;
        logic [4:0] n_mode;
        int         n_st;
        logic       src, edg, ctrl_w, kr, n_cmpprev;
        #1;
        chk(kill ? "R10" : "R4", tc_o, m_tc() && !kill);
        chk(kill ? "R10" : (m_mode[3] ? "R9" : "R8"), cmp_o,
            !kill && (m_mode[3] ? m_cmpprev : m_cmp()));
        chk(kill ? "R10" : "R12", irq_o, !kill && (m_mode[2] ? m_cmp() : m_tc()));
        chk(rd_tag(ad), rdata, m_rd(ad));
        last_rd = rdata;
        #4;
        chk(kill ? "R10" : "R4", tc_o, m_tc() && !kill && !m_mode[4]);
        chk(kill ? "R10" : (m_mode[3] ? "R9" : "R8"), cmp_o, !kill && m_cmp());

        kr     = m_mode[0];
        ctrl_w = wr && (ad == 3'd3);
        src    = cap | (rd && (ad == 3'd0) && (m_st != 0));
        edg    = src && !m_capprev;
        n_cc   = edg ? m_cnt : ((wr && ad == 3'd2) ? wd : m_cc);
        n_per  = (wr && ad == 3'd1) ? wd : m_per;
        n_lim  = ctrl_w ? wd[7:4] : m_lim;
        n_mode = (wr && ad == 3'd4) ? wd[4:0] : m_mode;
        n_st   = m_st;
        n_cnt  = m_cnt;
        n_sh   = m_sh;
        case (m_st)
            0: begin
                if (wr && ad == 3'd1) n_cnt = wd;
                if (ctrl_w && wd[0] && !(kill && !kr)) begin
                    n_sh = 4'd0;
                    if (kill) begin
                        n_st  = 2;
                        n_cnt = m_per;
                    end else begin
                        n_st = 1;
                    end
                end
            end
            1: begin
                if (ctrl_w && !wd[0]) begin
                    n_st = 0;
                end else if (kill) begin
                    if (kr) begin
                        n_st  = 2;
                        n_cnt = m_per;
                        n_sh  = 4'd0;
                    end else begin
                        n_st = 0;
                    end
                end else if (m_cnt == 8'd0) begin
                    n_cnt = m_per;
                    if (m_lim != 4'd0 && (m_sh + 4'd1) == m_lim) n_st = 0;
                    n_sh = m_sh + 4'd1;
                end else begin
                    n_cnt = m_cnt - 8'd1;
                end
            end
            default: begin
                n_cnt = m_per;
                n_sh  = 4'd0;
                if (ctrl_w && !wd[0])   n_st = 0;
                else if (kill && !kr)   n_st = 0;
                else if (!kill)         n_st = 1;
            end
        endcase
        n_cmpprev = m_cmp();

        @(posedge clk);
        m_st      = n_st;
        m_cnt     = n_cnt;
        m_cc      = n_cc;
        m_per     = n_per;
        m_lim     = n_lim;
        m_sh      = n_sh;
        m_mode    = n_mode;
        m_capprev = src;
        m_cmpprev = n_cmpprev;
        #1;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        wr = 1'b1; ad = a; wd = d;
        step();
        wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 5; a++) begin
            ad = 3'(a);
            step();
            chk("R1", last_rd, 0);
        end
        chk("R1", {tc_o, cmp_o, irq_o}, 0);

        // R2: period write while idle loads count
        wr_reg(3'd1, 8'd5);
        ad = 3'd0;
        step();
        chk("R2", last_rd, 5);

        // R13: count address is read-only
        wr_reg(3'd0, 8'h77);
        ad = 3'd0;
        step();
        chk("R13", last_rd, 5);

        // R3/R4: free-running down count with reload
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd3, 8'h01);
        ad = 3'd0;
        for (int i = 0; i < 12; i++) begin
            step();
            chk("R3", last_rd, 5 - (i % 6));
        end

        // R7: software capture by reading the count while running
        rd = 1'b1; ad = 3'd0;
        step();
        v = last_rd;
        rd = 1'b0; ad = 3'd2;
        step();
        chk("R7", last_rd, v);

        // R6 hardware capture, then R7 read masked while cap_in high
        ad = 3'd0; cap = 1'b1;
        step();
        v = last_rd;
        rd = 1'b1;
        step();
        rd = 1'b0; ad = 3'd2;
        step();
        chk("R6", last_rd, v);
        chk("R7", last_rd, v);
        cap = 1'b0;
        step();

        // R5: two-shot run
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd1, 8'd2);
        wr_reg(3'd3, 8'h21);
        ad = 3'd0;
        repeat (8) step();
        ad = 3'd3;
        step();
        chk("R5", last_rd[0], 0);
        ad = 3'd0;
        step();
        chk("R5", last_rd, 2);

        // R7: read while idle does not capture
        ad = 3'd2;
        step();
        v = last_rd;
        rd = 1'b1; ad = 3'd0;
        step();
        rd = 1'b0; ad = 3'd2;
        step();
        chk("R7", last_rd, v);

        // R10: kill-disable
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd1, 8'd6);
        wr_reg(3'd3, 8'h01);
        ad = 3'd0;
        repeat (2) step();
        kill = 1'b1;
        step();
        kill = 1'b0; ad = 3'd3;
        step();
        chk("R10", last_rd[0], 0);
        kill = 1'b1;
        wr_reg(3'd3, 8'h01);
        kill = 1'b0; ad = 3'd3;
        step();
        chk("R10", last_rd[0], 0);

        // R11: kill-reload hold and resume
        wr_reg(3'd4, 8'h01);
        wr_reg(3'd1, 8'd4);
        wr_reg(3'd3, 8'h01);
        ad = 3'd0;
        repeat (2) step();
        kill = 1'b1;
        repeat (3) step();
        chk("R11", last_rd, 4);
        kill = 1'b0;
        step();
        step();
        chk("R11", last_rd, 4);
        step();
        chk("R11", last_rd, 3);

        // Random phase: R8 R9 R12 and collisions
        for (int i = 0; i < 4000; i++) begin
            int r;
            wr = 1'b0; rd = 1'b0;
            r = int'($urandom % 100);
            if (r < 8) begin
                wr = 1'b1;
                ad = 3'($urandom % 6);
                wd = 8'($urandom);
                if (ad == 3'd1) wd = 8'($urandom % 12);
                if (ad == 3'd3 && ($urandom % 4) != 0) wd[0] = 1'b1;
            end else begin
                ad = 3'($urandom % 5);
                rd = (($urandom % 4) == 0);
            end
            if (($urandom % 16) == 0) cap = ~cap;
            if (($urandom % 25) == 0) kill = ~kill;
            step();
        end
        wr = 1'b0; rd = 1'b0;
        finish_run();
    end

endmodule